// File: doc/BRIEF.md
# Dual-Clock FIFO with Shared Status Flags

This block is a first-in first-out buffer, 1024 words deep and 36 bits wide, with a write port and a read port that each run on their own clock. Either port is enabled by an active-low strobe. A word is taken in on a write-clock rising edge when the buffer has room. A word is presented on a registered output on a read-clock rising edge when the buffer holds data. The two clocks may be fully unrelated, or they may be the same net.

Status leaves the block on four flag pins, and three of them are shared. The empty/full pin is high when the buffer holds no words or holds all 1024. The quarter pin is high when the buffer holds 256 words or fewer, or when it holds 768 or more. The condition near empty is produced by the read clock and the condition near full by the write clock, so each half follows the port whose activity changes it. A half-full pin and a sticky fault pin complete the set. The fault pin reports an enabled read while empty or an enabled write while full, and it stays set until that condition goes away.

An active-low master reset empties the buffer and clears the data output to zero. An active-low output enable switches the data output between driving and high impedance. The occupancy seen by each side is the difference between its own pointer and a two-flop synchronised Gray copy of the other side's pointer.

Top module: `flag_fifo`

## Requirements
- R1: A word on wr_data is stored on a wr_clk rising edge when wr_en_n is 0 and the buffer holds fewer than 1024 words, and words leave in the order they were stored.
- R2: rd_data changes only on a rd_clk rising edge with rd_en_n at 0 and at least one word stored; an enabled read while empty leaves rd_data unchanged.
- R3: A write attempted while 1024 words are stored is discarded and does not disturb the stored words or their order.
- R4: Once the ports are quiet, ef_flag is 1 when 0 words are stored and 0 for any count from 1 to 1023.
- R5: Once the ports are quiet, ef_flag is 1 when 1024 words are stored.
- R6: Once the ports are quiet, qt_flag is 1 for counts of 256 or fewer and for counts of 768 or more, and 0 for counts from 257 to 767.
- R7: Once the ports are quiet, hf_flag is 1 for counts above 512 and 0 for counts of 512 or fewer.
- R8: An enabled read while empty sets fault_flag, which stays 1 while the buffer stays empty and returns to 0 once a word has been written.
- R9: An enabled write while full sets fault_flag, which stays 1 while the buffer stays full and returns to 0 once a word has been read.
- R10: While mrst_n is 0 for several cycles of both clocks, the buffer becomes empty: ef_flag=1, qt_flag=1, hf_flag=0, fault_flag=0 and rd_data=0 with out_en_n at 0.
- R11: With out_en_n at 1 the rd_data pins are high impedance, and with out_en_n at 0 they show the last word read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| mrst_n | input | 1 | Master reset, active low, sampled by both clocks |
| wr_en_n | input | 1 | Write strobe, active low |
| wr_data | input | 36 | Word to store |
| rd_en_n | input | 1 | Read strobe, active low |
| out_en_n | input | 1 | Data output drive enable, active low |
| rd_data | output | 36 | Registered read word, high impedance when out_en_n is 1 |
| ef_flag | output | 1 | Empty (read side) or full (write side) |
| qt_flag | output | 1 | At most a quarter (read side) or at least three quarters (write side) |
| hf_flag | output | 1 | More than half full, write side |
| fault_flag | output | 1 | Sticky underflow or overflow attempt |

## Verification
A bad pointer or a bad synchroniser stage shows up as a wrong count. When the ports go quiet, one of the threshold pins then flips at the wrong boundary: 256/257, 512/513 or 767/768. It also shows up within one read as a word out of order, missing or repeated. A fault bit that never releases, or that releases early, shows up at fault_flag a few cycles of the opposite clock after the releasing transfer. A read pointer that moves while empty gives a changed rd_data on the very next read edge.

// File: rtl/ffq_pkg.sv
package ffq_pkg;

    localparam int DEF_DEPTH  = 1024;
    localparam int DEF_WIDTH  = 36;
    localparam int DEF_STAGES = 2;

    // one port's contribution to the shared pins
    typedef struct packed {
        logic edge_hit;   // empty on read side, full on write side
        logic band_hit;   // quarter on read side, three quarters on write side
        logic sticky;     // latched misuse
    } side_flags_t;

    function automatic logic [31:0] to_gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [31:0] from_gray(input logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/ffq_ptr_sync.sv
module ffq_ptr_sync #(
    parameter int PW     = 11,
    parameter int STAGES = ffq_pkg::DEF_STAGES
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] src_gray,
    output logic [PW-1:0] dst_bin
);
    import ffq_pkg::*;

    logic [PW-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (!rst_n) stg[s] <= '0;
                else        stg[s] <= src_gray;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (!rst_n) stg[s] <= '0;
                else        stg[s] <= stg[s-1];
            end
        end
    end

    assign dst_bin = PW'(from_gray(32'(stg[STAGES-1])));

endmodule

// File: rtl/ffq_wr_side.sv
module ffq_wr_side #(
    parameter int DEPTH = ffq_pkg::DEF_DEPTH,
    parameter int PW    = $clog2(DEPTH) + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en_n,
    input  logic [PW-1:0]       peer_bin,
    output logic [PW-1:0]       ptr_bin,
    output logic [PW-1:0]       ptr_gray,
    output logic                go,
    output logic                half,
    output ffq_pkg::side_flags_t flags
);
    import ffq_pkg::*;

    localparam logic [PW-1:0] FULL_CNT = PW'(DEPTH);
    localparam logic [PW-1:0] HALF_CNT = PW'(DEPTH / 2);
    localparam logic [PW-1:0] TQ_CNT   = PW'(DEPTH - DEPTH / 4);

    logic [PW-1:0] ptr_nxt, cnt_nxt;
    logic          full_nxt;

    assign go       = !en_n && !flags.edge_hit;
    assign ptr_nxt  = ptr_bin + PW'(go);
    assign cnt_nxt  = ptr_nxt - peer_bin;
    assign full_nxt = (cnt_nxt == FULL_CNT);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_bin  <= '0;
            ptr_gray <= '0;
            half     <= 1'b0;
            flags    <= '0;
        end else begin
            ptr_bin        <= ptr_nxt;
            ptr_gray       <= PW'(to_gray(32'(ptr_nxt)));
            half           <= (cnt_nxt > HALF_CNT);
            flags.edge_hit <= full_nxt;
            flags.band_hit <= (cnt_nxt >= TQ_CNT);
            flags.sticky   <= full_nxt && (flags.sticky || (!en_n && flags.edge_hit));
        end
    end

endmodule

// File: rtl/ffq_rd_side.sv
module ffq_rd_side #(
    parameter int DEPTH = ffq_pkg::DEF_DEPTH,
    parameter int PW    = $clog2(DEPTH) + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en_n,
    input  logic [PW-1:0]       peer_bin,
    output logic [PW-1:0]       ptr_bin,
    output logic [PW-1:0]       ptr_gray,
    output logic                go,
    output ffq_pkg::side_flags_t flags
);
    import ffq_pkg::*;

    localparam logic [PW-1:0] QTR_CNT = PW'(DEPTH / 4);

    logic [PW-1:0] ptr_nxt, cnt_nxt;
    logic          empty_nxt;

    assign go        = !en_n && !flags.edge_hit;
    assign ptr_nxt   = ptr_bin + PW'(go);
    assign cnt_nxt   = peer_bin - ptr_nxt;
    assign empty_nxt = (cnt_nxt == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_bin  <= '0;
            ptr_gray <= '0;
            flags    <= '{edge_hit: 1'b1, band_hit: 1'b1, sticky: 1'b0};
        end else begin
            ptr_bin        <= ptr_nxt;
            ptr_gray       <= PW'(to_gray(32'(ptr_nxt)));
            flags.edge_hit <= empty_nxt;
            flags.band_hit <= (cnt_nxt <= QTR_CNT);
            flags.sticky   <= empty_nxt && (flags.sticky || (!en_n && flags.edge_hit));
        end
    end

endmodule

// File: rtl/ffq_store.sv
module ffq_store #(
    parameter int W     = ffq_pkg::DEF_WIDTH,
    parameter int DEPTH = ffq_pkg::DEF_DEPTH,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          wr_clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge wr_clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/flag_fifo.sv
module flag_fifo #(
    parameter int W      = ffq_pkg::DEF_WIDTH,
    parameter int DEPTH  = ffq_pkg::DEF_DEPTH,
    parameter int STAGES = ffq_pkg::DEF_STAGES
) (
    input  logic         wr_clk,
    input  logic         rd_clk,
    input  logic         mrst_n,
    input  logic         wr_en_n,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en_n,
    input  logic         out_en_n,
    output logic [W-1:0] rd_data,
    output logic         ef_flag,
    output logic         qt_flag,
    output logic         hf_flag,
    output logic         fault_flag
);
    import ffq_pkg::*;

    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic [PW-1:0] wr_bin, wr_gray, rd_bin, rd_gray;
    logic [PW-1:0] rd_in_wr, wr_in_rd;
    logic          wr_go, rd_go, half_w;
    side_flags_t   wflags, rflags;
    logic [W-1:0]  mem_q, rd_q;

    ffq_wr_side #(.DEPTH(DEPTH), .PW(PW)) u_wr (
        .clk(wr_clk), .rst_n(mrst_n), .en_n(wr_en_n), .peer_bin(rd_in_wr),
        .ptr_bin(wr_bin), .ptr_gray(wr_gray), .go(wr_go), .half(half_w),
        .flags(wflags)
    );

    ffq_rd_side #(.DEPTH(DEPTH), .PW(PW)) u_rd (
        .clk(rd_clk), .rst_n(mrst_n), .en_n(rd_en_n), .peer_bin(wr_in_rd),
        .ptr_bin(rd_bin), .ptr_gray(rd_gray), .go(rd_go), .flags(rflags)
    );

    ffq_ptr_sync #(.PW(PW), .STAGES(STAGES)) u_sync_r2w (
        .clk(wr_clk), .rst_n(mrst_n), .src_gray(rd_gray), .dst_bin(rd_in_wr)
    );

    ffq_ptr_sync #(.PW(PW), .STAGES(STAGES)) u_sync_w2r (
        .clk(rd_clk), .rst_n(mrst_n), .src_gray(wr_gray), .dst_bin(wr_in_rd)
    );

    ffq_store #(.W(W), .DEPTH(DEPTH), .AW(AW)) u_mem (
        .wr_clk(wr_clk), .we(wr_go), .waddr(wr_bin[AW-1:0]), .wdata(wr_data),
        .raddr(rd_bin[AW-1:0]), .rdata(mem_q)
    );

    always_ff @(posedge rd_clk) begin
        if (!mrst_n)    rd_q <= '0;
        else if (rd_go) rd_q <= mem_q;
    end

    assign rd_data    = out_en_n ? {W{1'bz}} : rd_q;
    assign ef_flag    = rflags.edge_hit | wflags.edge_hit;
    assign qt_flag    = rflags.band_hit | wflags.band_hit;
    assign hf_flag    = half_w;
    assign fault_flag = rflags.sticky | wflags.sticky;

endmodule

// File: rtl/flag_fifo_chk.sv
module flag_fifo_chk #(
    parameter int W  = 36,
    parameter int PW = 11
) (
    input logic          wr_clk,
    input logic          rd_clk,
    input logic          mrst_n,
    input logic [PW-1:0] wr_bin,
    input logic [PW-1:0] rd_bin,
    input logic [W-1:0]  rd_q,
    input logic          full_w,
    input logic          tq_w,
    input logic          half_w,
    input logic          oflow_w,
    input logic          empty_r,
    input logic          qtr_r,
    input logic          uflow_r
);
    // R3: write pointer frozen while full
    a_r3_no_overflow: assert property (@(posedge wr_clk) disable iff (!mrst_n)
        full_w |=> $stable(wr_bin));

    // R2: output word and read pointer frozen while empty
    a_r2_hold_when_empty: assert property (@(posedge rd_clk) disable iff (!mrst_n)
        empty_r |=> ($stable(rd_q) && $stable(rd_bin)));

    // R5 R7: full implies the upper thresholds
    a_r5_full_thresholds: assert property (@(posedge wr_clk) disable iff (!mrst_n)
        full_w |-> (tq_w && half_w));

    // R4 R6: empty implies the lower threshold
    a_r4_empty_quarter: assert property (@(posedge rd_clk) disable iff (!mrst_n)
        empty_r |-> qtr_r);

    // R9: overflow fault only while full
    a_r9_oflow_needs_full: assert property (@(posedge wr_clk) disable iff (!mrst_n)
        oflow_w |-> full_w);

    // R8: underflow fault only while empty
    a_r8_uflow_needs_empty: assert property (@(posedge rd_clk) disable iff (!mrst_n)
        uflow_r |-> empty_r);

endmodule

bind flag_fifo flag_fifo_chk #(.W(W), .PW(PW)) u_chk (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .mrst_n(mrst_n),
    .wr_bin(wr_bin), .rd_bin(rd_bin), .rd_q(rd_q),
    .full_w(wflags.edge_hit), .tq_w(wflags.band_hit), .half_w(half_w),
    .oflow_w(wflags.sticky), .empty_r(rflags.edge_hit), .qtr_r(rflags.band_hit),
    .uflow_r(rflags.sticky)
);

// File: tb/tb_flag_fifo.sv
`timescale 1ns/1ps
module tb_flag_fifo;
    localparam int W = 36;
    localparam int DEPTH = 1024;
    localparam int NV = 14;
    // {count[10:0], ef, qt, hf}
    localparam logic [13:0] VEC [NV] = '{
        {11'd0,    3'b110}, {11'd1,    3'b010}, {11'd256,  3'b010},
        {11'd257,  3'b000}, {11'd512,  3'b000}, {11'd513,  3'b001},
        {11'd767,  3'b001}, {11'd768,  3'b011}, {11'd1023, 3'b011},
        {11'd1024, 3'b111}, {11'd800,  3'b011}, {11'd512,  3'b000},
        {11'd256,  3'b010}, {11'd0,    3'b110}
    };

    logic wr_clk = 0, rd_clk = 0, mrst_n = 0;
    logic wr_en_n = 1, rd_en_n = 1, out_en_n = 0;
    logic [W-1:0] wr_data = '0;
    wire  [W-1:0] rd_data;
    wire  ef_flag, qt_flag, hf_flag, fault_flag;

    int checks = 0, fails = 0, wseq = 0;
    bit done = 0;
    logic [W-1:0] model [$];
    logic [W-1:0] last_word = '0;

    always #2   wr_clk = ~wr_clk;
    always #3.5 rd_clk = ~rd_clk;

    flag_fifo dut (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .mrst_n(mrst_n), .wr_en_n(wr_en_n),
        .wr_data(wr_data), .rd_en_n(rd_en_n), .out_en_n(out_en_n),
        .rd_data(rd_data), .ef_flag(ef_flag), .qt_flag(qt_flag),
        .hf_flag(hf_flag), .fault_flag(fault_flag)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (6) @(posedge wr_clk);
        repeat (6) @(posedge rd_clk);
        @(negedge rd_clk);
    endtask

    task automatic push();
        logic [W-1:0] d;
        d = {wseq[17:0], ~wseq[17:0]};
        wseq++;
        @(negedge wr_clk);
        wr_en_n = 0;
        wr_data = d;
        @(negedge wr_clk);
        wr_en_n = 1;
        if (model.size() < DEPTH) model.push_back(d);
    endtask

    task automatic pop(input string req);
        @(negedge rd_clk);
        rd_en_n = 0;
        @(negedge rd_clk);
        rd_en_n = 1;
        if (model.size() > 0) begin
            last_word = model.pop_front();
            chk(req, rd_data, last_word);
        end else begin
            chk(req, rd_data, last_word);
        end
    endtask

    task automatic flags_are(input string req, input logic ef, input logic qt,
                             input logic hf, input logic flt);
        chk({req, " ef"}, W'(ef_flag), W'(ef));
        chk({req, " qt"}, W'(qt_flag), W'(qt));
        chk({req, " hf"}, W'(hf_flag), W'(hf));
        chk({req, " fault"}, W'(fault_flag), W'(flt));
    endtask

    task automatic do_reset();
        mrst_n = 0;
        repeat (10) @(posedge rd_clk);
        repeat (10) @(posedge wr_clk);
        @(negedge wr_clk);
        mrst_n = 1;
        model.delete();
        last_word = '0;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        do_reset();
        settle();
        // R10: state after reset
        flags_are("R10 reset", 1'b1, 1'b1, 1'b0, 1'b0);
        chk("R10 rd_data zero", rd_data, '0);

        // R1 R4 R5 R6 R7: threshold walk
        for (int v = 0; v < NV; v++) begin
            int tgt;
            tgt = int'(VEC[v][13:3]);
            while (model.size() < tgt) push();
            settle();
            while (model.size() > tgt) pop("R1 order");
            settle();
            flags_are($sformatf("R4 R5 R6 R7 count=%0d", tgt),
                      VEC[v][2], VEC[v][1], VEC[v][0], 1'b0);
        end

        // R8: read while empty
        pop("R2 hold on empty read");
        settle();
        chk("R8 fault set", W'(fault_flag), W'(1));
        settle();
        chk("R8 fault held", W'(fault_flag), W'(1));
        push();
        settle();
        chk("R8 fault released", W'(fault_flag), W'(0));
        pop("R1 order");
        settle();

        // R3 R9: write while full
        while (model.size() < DEPTH) push();
        push(); push(); push();
        settle();
        chk("R9 fault set", W'(fault_flag), W'(1));
        chk("R5 full", W'(ef_flag), W'(1));
        pop("R3 order at full");
        settle();
        chk("R9 fault released", W'(fault_flag), W'(0));
        while (model.size() > 0) pop("R3 extra words dropped");
        settle();
        chk("R4 empty after drain", W'(ef_flag), W'(1));

        // R11: output enable
        push();
        settle();
        pop("R1 order");
        @(negedge rd_clk);
        out_en_n = 1;
        #1;
        chk("R11 released", W'(rd_data !== last_word), W'(1));
        out_en_n = 0;
        #1;
        chk("R11 driven", rd_data, last_word);

        // R10: reset with data stored
        repeat (5) push();
        settle();
        do_reset();
        settle();
        flags_are("R10 mid reset", 1'b1, 1'b1, 1'b0, 1'b0);
        chk("R10 rd_data zero", rd_data, '0);
        push();
        settle();
        pop("R1 after reset");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule